// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer Counter

A timebase for a family of capture/compare channels. A free-running system clock drives the block. One of four single-cycle tick enables is chosen as the count source. A prescaler divides that source by 1, 2, 4 or 8. Each prescaled tick advances a 16-bit counter in one of four modes: stopped, up to a period value, continuous through the full range, or up to the period and back down to zero.

The channels that use the block read the counter value and the period-match strobe. The period comes from compare register 0 on its own input. Software programs a single control word. That word holds the source and divider selects, the mode, a self-clearing clear command, an interrupt enable and the overflow flag. The flag marks each return of the counter to zero. Software clears it by writing 0, and the flag raises the interrupt request while enabled.

Top module: `timebase_counter`

## Requirements
- R1: Control bits [9:8] pick the count source. Code k (0..3) makes `tick_en[k]` the only input that advances the prescaler. A pulse on any other `tick_en` bit has no effect.
- R2: Control bits [7:6] set the prescale. Codes 0, 1, 2 and 3 give one counter step per 1, 2, 4 or 8 selected-source pulses.
- R3: Mode code 0 (control bits [5:4]) holds the counter and direction at their current values.
- R4: In mode 1, each step adds 1 until the counter equals `period`. The next step then sets it to 0. If the counter lies above `period`, it runs on to 0xFFFF and then wraps to 0.
- R5: In mode 2, each step adds 1, and the step after 0xFFFF gives 0.
- R6: In mode 3, the counter rises to `period` and then falls to 0 before rising again. `dir_down` is 1 while the counter falls. In modes 1 and 2, any step sets `dir_down` to 0.
- R7: Writing control bit 2 as 1 sets the counter, the prescaler state, `dir_down` and `equ` to 0 in the next cycle. No step happens in that cycle. Bit 2 of `ctl_rdata` always reads 0.
- R8: `flag` (control bit 0) is set by a step that takes the counter to 0 from a nonzero value, in any counting mode. It then stays set until a control write supplies bit 0 = 0. If a write and a setting step fall in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when `flag` is 1 and the enable bit (control bit 1) is 1.
- R10: `equ` is high for the one cycle after each step taken while the counter equals `period`, and low otherwise.
- R11: The mode, divider and source written in a cycle govern the steps from the next cycle on. The counter changes only on a step or a clear.
- R12: After reset, the counter, `dir_down`, `equ`, `flag`, `irq` and `ctl_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 4 | Candidate tick enables: external, auxiliary, sub-main, inverted external |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 10 | Control word to write |
| period | input | 16 | Period value from compare register 0 |
| ctl_rdata | output | 10 | Control word read-back |
| count | output | 16 | Counter value |
| dir_down | output | 1 | 1 while counting down in mode 3 |
| equ | output | 1 | Period-match strobe |
| flag | output | 1 | Overflow interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
Random tick patterns on all four enables, together with sparse random control writes and small periods, exercise the modes against a cycle model. Those runs tell apart errors in the turn points of up and up/down counting, flag and strobe timing, and the effect of clears arriving mid-prescale. Directed runs drive only unselected sources to separate source selection from the divider. They also count pulses at /4 to expose a wrong prescale. A long run at full rate in continuous mode reaches the 0xFFFF wrap, which random stimulus with short periods never touches.

// File: rtl/timebase_counter.sv
module timebase_counter #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       tick_en,
  input  logic             ctl_we,
  input  logic [9:0]       ctl_wdata,
  input  logic [CNT_W-1:0] period,
  output logic [9:0]       ctl_rdata,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             equ,
  output logic             flag,
  output logic             irq
);
  localparam logic [CNT_W-1:0] TOP = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [1:0]       src_q, div_q, mode;
  logic             irq_en;
  logic [PRE_W-1:0] pre_q, pre_mask, pre_nxt;
  logic             src_hit, pre_fire, clr_w, step, evt, ndir;
  logic [CNT_W-1:0] nxt;

  assign clr_w    = ctl_we & ctl_wdata[2];
  assign src_hit  = tick_en[src_q];
  assign pre_mask = PRE_W'((1 << div_q) - 1);
  assign pre_fire = src_hit && (pre_q >= pre_mask);
  assign step     = pre_fire && (mode != 2'd0) && !clr_w;
  assign pre_nxt  = !src_hit ? pre_q : (pre_fire ? '0 : pre_q + 1'b1);
  assign irq       = flag & irq_en;
  assign ctl_rdata = {src_q, div_q, mode, 2'b00, irq_en, flag};

  always_comb begin
    nxt  = count;
    ndir = dir_down;
    evt  = 1'b0;
    case (mode)
      2'd1: begin
        ndir = 1'b0;
        if (count == period || count == TOP) begin
          nxt = '0;
          evt = (count != '0);
        end else nxt = count + ONE;
      end
      2'd2: begin
        ndir = 1'b0;
        nxt  = count + ONE;
        evt  = (count == TOP);
      end
      2'd3: begin
        if (!dir_down && count < period) nxt = count + ONE;
        else if (count <= ONE) begin
          nxt  = '0;
          ndir = 1'b0;
          evt  = (count == ONE);
        end else begin
          nxt  = count - ONE;
          ndir = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      div_q    <= '0;
      mode     <= '0;
      irq_en   <= 1'b0;
      flag     <= 1'b0;
      pre_q    <= '0;
      count    <= '0;
      dir_down <= 1'b0;
      equ      <= 1'b0;
    end else begin
      if (ctl_we) begin
        src_q  <= ctl_wdata[9:8];
        div_q  <= ctl_wdata[7:6];
        mode   <= ctl_wdata[5:4];
        irq_en <= ctl_wdata[1];
      end
      flag <= (step & evt) | (ctl_we ? ctl_wdata[0] : flag);
      if (clr_w) begin
        pre_q    <= '0;
        count    <= '0;
        dir_down <= 1'b0;
        equ      <= 1'b0;
      end else begin
        pre_q <= pre_nxt;
        equ   <= step && (count == period);
        if (step) begin
          count    <= nxt;
          dir_down <= ndir;
        end
      end
    end
  end
endmodule

// File: rtl/timebase_counter_chk.sv
module timebase_counter_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          step,
  input logic          clr_w,
  input logic          ctl_we,
  input logic [CW-1:0] count,
  input logic [CW-1:0] period,
  input logic          dir_down,
  input logic          equ,
  input logic          flag
);
  assert_stop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !clr_w) |=> ($stable(count) && $stable(dir_down)));

  assert_cont_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == 2'd2) |=> (count == CW'($past(count) + 1'b1)));

  assert_updown_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == 2'd3 && count <= period) |=> (count <= $past(period)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> (count == '0 && !dir_down && !equ));

  assert_flag_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(step) || $past(ctl_we)));

  assert_equ_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    equ |-> $past(step));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr_w) |=> $stable(count));
endmodule

bind timebase_counter timebase_counter_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .step(step), .clr_w(clr_w),
  .ctl_we(ctl_we), .count(count), .period(period), .dir_down(dir_down),
  .equ(equ), .flag(flag)
);

// File: tb/tb_timebase_counter.sv
module tb_timebase_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tick_en = '0;
  logic        ctl_we = 1'b0;
  logic [9:0]  ctl_wdata = '0;
  logic [15:0] period = '0;
  logic [9:0]  ctl_rdata;
  logic [15:0] count;
  logic        dir_down, equ, flag, irq;

  int total = 0;
  int bad = 0;

  logic [15:0] m_cnt;
  logic        m_dir, m_equ, m_flag, m_ien;
  logic [1:0]  m_src, m_div, m_mode;
  logic [2:0]  m_pre;
  string       cnt_tag = "R12";

  timebase_counter dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .period(period), .ctl_rdata(ctl_rdata),
    .count(count), .dir_down(dir_down), .equ(equ), .flag(flag), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(cnt_tag, "count", count, m_cnt);
    check("R6", "dir_down", dir_down, m_dir);
    check("R10", "equ", equ, m_equ);
    check("R8", "flag", flag, m_flag);
    check("R9", "irq", irq, m_flag & m_ien);
    check("R7", "ctl_rdata", ctl_rdata, {m_src, m_div, m_mode, 2'b00, m_ien, m_flag});
  endtask

  task automatic model_step(input logic [3:0] t, input logic we, input logic [9:0] wd);
    logic hit, fire, stp, ev, nd, clr;
    logic [2:0] mask;
    logic [15:0] nx;
    clr  = we & wd[2];
    mask = 3'((1 << m_div) - 1);
    hit  = t[m_src];
    fire = hit && (m_pre >= mask);
    stp  = fire && (m_mode != 0) && !clr;
    nx = m_cnt; nd = m_dir; ev = 1'b0;
    case (m_mode)
      2'd0: cnt_tag = "R3";
      2'd1: begin
        cnt_tag = "R4"; nd = 1'b0;
        if (m_cnt == period || m_cnt == 16'hFFFF) begin nx = 0; ev = (m_cnt != 0); end
        else nx = m_cnt + 1;
      end
      2'd2: begin cnt_tag = "R5"; nd = 1'b0; nx = m_cnt + 1; ev = (m_cnt == 16'hFFFF); end
      default: begin
        cnt_tag = "R6";
        if (!m_dir && m_cnt < period) nx = m_cnt + 1;
        else if (m_cnt <= 1) begin nx = 0; nd = 1'b0; ev = (m_cnt == 1); end
        else begin nx = m_cnt - 1; nd = 1'b1; end
      end
    endcase
    if (clr) cnt_tag = "R7";
    m_flag = (stp & ev) | (we ? wd[0] : m_flag);
    if (clr) begin
      m_pre = 0; m_cnt = 0; m_dir = 0; m_equ = 0;
    end else begin
      m_equ = stp && (m_cnt == period);
      if (hit) m_pre = fire ? 3'd0 : m_pre + 3'd1;
      if (stp) begin m_cnt = nx; m_dir = nd; end
    end
    if (we) begin
      m_src = wd[9:8]; m_div = wd[7:6]; m_mode = wd[5:4]; m_ien = wd[1];
    end
  endtask

  task automatic cyc(input logic [3:0] t, input logic we, input logic [9:0] wd);
    tick_en = t; ctl_we = we; ctl_wdata = wd;
    model_step(t, we, wd);
    @(negedge clk);
    compare_all();
    tick_en = '0; ctl_we = 1'b0;
  endtask

  function automatic logic [9:0] cw(input int src, input int dv, input int md, input int clr, input int ie, input int fl);
    return {2'(src), 2'(dv), 2'(md), 1'b0, 1'(clr), 1'(ie), 1'(fl)};
  endfunction

  initial begin
    #(CLK_PERIOD * 300000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] snap;
    void'($urandom(32'd2024));
    m_cnt = 0; m_dir = 0; m_equ = 0; m_flag = 0; m_ien = 0;
    m_src = 0; m_div = 0; m_mode = 0; m_pre = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", "reset count", count, 0);
    check("R12", "reset outputs", {dir_down, equ, flag, irq}, 0);
    check("R12", "reset ctl_rdata", ctl_rdata, 0);

    // R1: source 1 selected, pulses only on source 0 and 2
    period = 16'd100;
    cyc(4'b0000, 1'b1, cw(1, 0, 2, 1, 0, 0));
    snap = count;
    repeat (10) cyc(4'b0101, 1'b0, '0);
    check("R1", "unselected source ignored", count, snap);
    repeat (5) cyc(4'b0010, 1'b0, '0);
    check("R1", "selected source counts", count, snap + 5);

    // R2: divide by 4, 12 pulses -> 3 steps
    cyc(4'b0000, 1'b1, cw(3, 2, 2, 1, 0, 0));
    repeat (12) cyc(4'b1000, 1'b0, '0);
    check("R2", "div4 steps", count, 3);

    // R11: switch to stop, value kept
    snap = count;
    cyc(4'b1000, 1'b1, cw(3, 2, 0, 0, 0, 0));
    repeat (16) cyc(4'b1000, 1'b0, '0);
    check("R11", "stop keeps count", count, snap);

    // R7: clear bit reads back 0
    cyc(4'b0000, 1'b1, cw(0, 0, 1, 1, 1, 0));
    check("R7", "clear readback bit", ctl_rdata[2], 0);
    check("R7", "cleared count", count, 0);

    // R4 / R10: up mode period 3 wraps after 4 steps
    period = 16'd3;
    repeat (4) cyc(4'b0001, 1'b0, '0);
    check("R4", "up wrap", count, 0);
    check("R8", "flag on wrap", flag, 1);
    check("R9", "irq enabled", irq, 1);

    // R5: full-range continuous wrap
    cyc(4'b0000, 1'b1, cw(0, 0, 2, 1, 0, 0));
    repeat (65536) cyc(4'b0001, 1'b0, '0);
    check("R5", "continuous wrap count", count, 0);
    check("R8", "flag after 0xFFFF wrap", flag, 1);
    check("R9", "irq masked", irq, 0);

    // R6: up/down period 4
    period = 16'd4;
    cyc(4'b0000, 1'b1, cw(0, 0, 3, 1, 0, 0));
    repeat (6) cyc(4'b0001, 1'b0, '0);
    check("R6", "updown falling value", count, 2);
    check("R6", "updown direction", dir_down, 1);
    repeat (2) cyc(4'b0001, 1'b0, '0);
    check("R8", "flag at down zero", flag, 1);

    // random mix
    for (int i = 0; i < 30000; i++) begin
      logic we;
      logic [9:0] wd;
      we = ($urandom % 48) == 0;
      wd = 10'($urandom);
      if (($urandom % 4) != 0) wd[2] = 1'b0;
      if (we) period = 16'($urandom % 16);
      cyc(4'($urandom), we, wd);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule